// File: doc/BRIEF.md
# Wide-State Add-Shift-Rotate Random Block Generator

This block produces 1024-bit blocks of pseudo-random data. It keeps a 1024-bit mixing state, split into two independent halves. Each half holds two 256-bit words, and each word is four 64-bit lanes. It also keeps a 256-bit counter and a 1024-bit output register. A single step mixes the state with whole-word rotations, per-lane right shifts and per-lane 64-bit additions. The same step folds the counter into the state and computes a fresh output block.

The user loads a 256-bit seed with a one-cycle strobe. The block then runs a fixed 13-round warm-up, one round per clock, and raises its ready flag when the warm-up is done. After that, `blk_o` always shows the block that the next request will take. A request accepted while ready delivers that block and advances the generator by one step at the same clock edge.

Top module: `prng_wide`

## Requirements
- R1: After reset, `rdy_o` is 0 and `blk_o` is all zeros until a seed has been loaded and the warm-up has finished.
- R2: A clock edge with `seed_load_i` high clears the counter and loads the state from `seed_i`. `rdy_o` is then low for the next 12 cycles and goes high after the 13th edge that follows the load edge. The state is loaded as follows. Half h, word w (0 = first word, 1 = second word) uses pairs p = 4h+2w and p+1. Lane 2(p-4h-2w) of the word is constant C[2p] XOR seed word k(p). The lane after it is C[2p+1]. The seed word index is k(p) = 0,1,2,3,2,3,0,1 for p = 0..7. Seed word k sits at `seed_i[64k+63:64k]`. C is a fixed 16-entry table of 64-bit constants taken from the golden-ratio fraction, with C[0] = 0x9E3779B97F4A7C15.
- R3: One step acts on each half as follows. First the counter is added lane-wise to the second word: s1c = s1 + ctr. Then u = s0 with each lane shifted right by 1. t0 = s0 rotated left by 96 bits across 256 bits. t1 = s1c rotated left by 32 bits. The new first word is t0 + u and the new second word is t1 + (s1c >> 3), both lane-wise and modulo 2^64.
- R4: Every step, including the warm-up steps, adds 7, 5, 3 and 1 to counter lanes 0, 1, 2 and 3 respectively, modulo 2^64.
- R5: The new output block of a step has four 256-bit words. Word 0 is u XOR t1 of half 0 and word 1 is u XOR t1 of half 1. Word 2 is the new first word of half 0 XOR the new second word of half 1. Word 3 is the new second word of half 0 XOR the new first word of half 1.
- R6: `blk_o` shows the output register. A request is accepted at an edge where `req_i` and `rdy_o` are both high. The block delivered is the one shown before that edge. At that edge the register takes the newly computed block.
- R7: Each warm-up round performs one step and then replaces the state with the fresh output. The first word of half 0 takes word 3 and its second word takes word 2. The first word of half 1 takes word 1 and its second word takes word 0.
- R8: While `rdy_o` is low, `req_i` has no effect. While `rdy_o` is high and `req_i` is low, `blk_o` and the generator state hold.
- R9: In `blk_o`, word w sits at bits 256w+255:256w. Lane l of a word sits at bits 64l+63:64l of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load_i | input | 1 | Load strobe for `seed_i`; starts the warm-up |
| seed_i | input | 256 | Four 64-bit seed words, word 0 in the low bits |
| req_i | input | 1 | Request for one output block |
| rdy_o | output | 1 | Warm-up done, requests are accepted |
| blk_o | output | 1024 | Block delivered by the next accepted request |

## Verification
A fault in the state, the counter or the output register shows up in the very first block after the warm-up. That block already depends on 13 chained steps, so a wrong rotation amount, shift, lane order or reload mapping changes almost every bit of it. A counter fault that only appears after many steps shows up in the first later block that is requested, and the model comparison catches it there. A wrong handshake shows up within one cycle, either as a block that changes while idle or as a ready flag that rises on the wrong cycle.

// File: rtl/prng_pkg.sv
package prng_pkg;
  localparam int LANE_W = 64;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
  localparam int BLK_W  = 4 * WORD_W;
  localparam int SEED_W = WORD_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANE_W-1:0] lane_t;
  typedef enum logic [1:0] {PH_IDLE, PH_WARM, PH_RUN} phase_e;

  function automatic word_t rotl(word_t x, int unsigned n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t lane_add(word_t a, word_t b);
    word_t r;
    for (int l = 0; l < LANES; l++)
      r[l*LANE_W +: LANE_W] = a[l*LANE_W +: LANE_W] + b[l*LANE_W +: LANE_W];
    return r;
  endfunction

  function automatic word_t lane_shr(word_t x, int unsigned n);
    word_t r;
    for (int l = 0; l < LANES; l++)
      r[l*LANE_W +: LANE_W] = x[l*LANE_W +: LANE_W] >> n;
    return r;
  endfunction

  // Odd per-lane increment: lane 0 gets the largest
  function automatic word_t ctr_step();
    word_t r;
    for (int l = 0; l < LANES; l++)
      r[l*LANE_W +: LANE_W] = LANE_W'(2 * (LANES - 1 - l) + 1);
    return r;
  endfunction

  // Golden-ratio fraction digits
  function automatic lane_t golden(int unsigned idx);
    case (idx[3:0])
      4'd0:  return 64'h9E3779B97F4A7C15;
      4'd1:  return 64'hF39CC0605CEDC834;
      4'd2:  return 64'h1082276BF3A27251;
      4'd3:  return 64'hF86C6A11D0C18E95;
      4'd4:  return 64'h2767F0B153D27B7F;
      4'd5:  return 64'h0347045B5BF1827F;
      4'd6:  return 64'h01886F0928403002;
      4'd7:  return 64'hC1D64BA40F335E36;
      4'd8:  return 64'hF06AD7AE9717877E;
      4'd9:  return 64'h85839D6EFFBD7DC6;
      4'd10: return 64'h64D325D1C5371682;
      4'd11: return 64'hCADD0CCCFDFFBBE1;
      4'd12: return 64'h626E33B8D04B4331;
      4'd13: return 64'hBBF73C790D94F79D;
      4'd14: return 64'h471C4AB3ED3D82A5;
      default: return 64'hFEC507705E4AE6E5;
    endcase
  endfunction

  // Initial value of word w of half h for a given seed
  function automatic word_t seed_word(logic [SEED_W-1:0] seed, int unsigned h, int unsigned w);
    word_t r;
    for (int q = 0; q < 2; q++) begin
      int unsigned p, k;
      p = 4*h + 2*w + q;
      k = (p < 4) ? p : (p ^ 6);
      r[(2*q)*LANE_W +: LANE_W]   = golden(2*p) ^ seed[k*LANE_W +: LANE_W];
      r[(2*q+1)*LANE_W +: LANE_W] = golden(2*p + 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/prng_half_mix.sv
module prng_half_mix
  import prng_pkg::*;
#(
  parameter int ROT_A   = 96,
  parameter int ROT_B   = 32,
  parameter int SHIFT_A = 1,
  parameter int SHIFT_B = 3
) (
  input  word_t s0_i,
  input  word_t s1_i,
  input  word_t ctr_i,
  output word_t s0_o,
  output word_t s1_o,
  output word_t mix_o
);
  word_t s1c, u, t0, t1;

  always_comb begin
    s1c   = lane_add(s1_i, ctr_i);
    u     = lane_shr(s0_i, SHIFT_A);
    t0    = rotl(s0_i, ROT_A);
    t1    = rotl(s1c, ROT_B);
    s0_o  = lane_add(t0, u);
    s1_o  = lane_add(t1, lane_shr(s1c, SHIFT_B));
    mix_o = u ^ t1;
  end
endmodule

// File: rtl/prng_ctl.sv
module prng_ctl
  import prng_pkg::*;
#(
  parameter int INIT_ROUNDS = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seed_load_i,
  input  logic req_i,
  output logic rdy_o,
  output logic warm_o,
  output logic step_o
);
  localparam int CNT_W = $clog2(INIT_ROUNDS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INIT_ROUNDS - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (seed_load_i) begin
      phase_q <= PH_WARM;
      cnt_q   <= '0;
    end else if (phase_q == PH_WARM) begin
      if (cnt_q == LAST) phase_q <= PH_RUN;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign rdy_o  = (phase_q == PH_RUN);
  assign warm_o = (phase_q == PH_WARM);
  assign step_o = !seed_load_i && (warm_o || (rdy_o && req_i));
endmodule

// File: rtl/prng_wide.sv
module prng_wide
  import prng_pkg::*;
#(
  parameter int INIT_ROUNDS = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load_i,
  input  logic [SEED_W-1:0] seed_i,
  input  logic              req_i,
  output logic              rdy_o,
  output logic [BLK_W-1:0]  blk_o
);
  localparam int HALVES = 2;

  word_t s0_q [HALVES];
  word_t s1_q [HALVES];
  word_t s0_n [HALVES];
  word_t s1_n [HALVES];
  word_t mix  [HALVES];
  word_t ctr_q;
  logic [BLK_W-1:0] out_q, out_n;

  logic step_fire, warm_step;
  logic [LANE_W-1:0] ctr_lane0;

  prng_ctl #(.INIT_ROUNDS(INIT_ROUNDS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .seed_load_i(seed_load_i), .req_i(req_i),
    .rdy_o(rdy_o), .warm_o(warm_step), .step_o(step_fire)
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    prng_half_mix u_mix (
      .s0_i(s0_q[h]), .s1_i(s1_q[h]), .ctr_i(ctr_q),
      .s0_o(s0_n[h]), .s1_o(s1_n[h]), .mix_o(mix[h])
    );
  end

  assign out_n = {s1_n[0] ^ s0_n[1], s0_n[0] ^ s1_n[1], mix[1], mix[0]};
  assign ctr_lane0 = ctr_q[LANE_W-1:0];
  assign blk_o = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int h = 0; h < HALVES; h++) begin
        s0_q[h] <= '0;
        s1_q[h] <= '0;
      end
      ctr_q <= '0;
      out_q <= '0;
    end else if (seed_load_i) begin
      for (int h = 0; h < HALVES; h++) begin
        s0_q[h] <= seed_word(seed_i, h, 0);
        s1_q[h] <= seed_word(seed_i, h, 1);
      end
      ctr_q <= '0;
    end else if (step_fire) begin
      ctr_q <= lane_add(ctr_q, ctr_step());
      out_q <= out_n;
      if (warm_step) begin
        s0_q[0] <= out_n[3*WORD_W +: WORD_W];
        s1_q[0] <= out_n[2*WORD_W +: WORD_W];
        s0_q[1] <= out_n[1*WORD_W +: WORD_W];
        s1_q[1] <= out_n[0*WORD_W +: WORD_W];
      end else begin
        for (int h = 0; h < HALVES; h++) begin
          s0_q[h] <= s0_n[h];
          s1_q[h] <= s1_n[h];
        end
      end
    end
  end
endmodule

// File: rtl/prng_wide_chk.sv
module prng_wide_chk
  import prng_pkg::*;
#(
  parameter int INIT_ROUNDS = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_load_i,
  input logic              req_i,
  input logic              rdy_o,
  input logic [BLK_W-1:0]  blk_o,
  input logic              step_fire,
  input logic              warm_step,
  input logic [LANE_W-1:0] ctr_lane0
);
  localparam int CNT_W = $clog2(INIT_ROUNDS + 1);

  logic             seen_q;
  logic [CNT_W-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      since_q <= '0;
    end else if (seed_load_i) begin
      seen_q  <= 1'b1;
      since_q <= '0;
    end else if (since_q < CNT_W'(INIT_ROUNDS)) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R1, R2: ready only after a load and the full warm-up
  a_r2_warmup_len: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> (seen_q && since_q == CNT_W'(INIT_ROUNDS)));

  a_r2_load_drops_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_i |=> !rdy_o);

  a_r4_ctr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_i |=> (ctr_lane0 == '0));

  a_r4_ctr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !seed_load_i) |=> (ctr_lane0 == $past(ctr_lane0) + LANE_W'(2 * (LANES - 1) + 1)));

  a_r6_step_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    (step_fire && !warm_step) |-> (rdy_o && req_i));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !req_i && !seed_load_i) |=> $stable(blk_o));

  a_r8_rdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !seed_load_i) |=> rdy_o);
endmodule

bind prng_wide prng_wide_chk #(.INIT_ROUNDS(INIT_ROUNDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load_i(seed_load_i), .req_i(req_i),
  .rdy_o(rdy_o), .blk_o(blk_o), .step_fire(step_fire),
  .warm_step(warm_step), .ctr_lane0(ctr_lane0)
);

// File: tb/prng_wide_bench.sv
`timescale 1ns/1ps
module prng_wide_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          seed_load_i = 1'b0;
  logic [255:0]  seed_i = '0;
  logic          req_i = 1'b0;
  logic          rdy_o;
  logic [1023:0] blk_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prng_wide u_prng_wide (
    .clk(clk), .rst_n(rst_n), .seed_load_i(seed_load_i), .seed_i(seed_i),
    .req_i(req_i), .rdy_o(rdy_o), .blk_o(blk_o)
  );

  // Reference model: m_st[half][word][lane], 64-bit lanes
  logic [63:0] m_st [2][2][4];
  logic [63:0] m_ct [4];
  logic [63:0] m_out [16];
  logic [63:0] consts [16] = '{
    64'h9E3779B97F4A7C15, 64'hF39CC0605CEDC834, 64'h1082276BF3A27251, 64'hF86C6A11D0C18E95,
    64'h2767F0B153D27B7F, 64'h0347045B5BF1827F, 64'h01886F0928403002, 64'hC1D64BA40F335E36,
    64'hF06AD7AE9717877E, 64'h85839D6EFFBD7DC6, 64'h64D325D1C5371682, 64'hCADD0CCCFDFFBBE1,
    64'h626E33B8D04B4331, 64'hBBF73C790D94F79D, 64'h471C4AB3ED3D82A5, 64'hFEC507705E4AE6E5};
  int seed_of_pair [8] = '{0, 1, 2, 3, 2, 3, 0, 1};

  task automatic chk(input bit ok, input string req, input logic [1023:0] act, input logic [1023:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1023:0] m_blk();
    logic [1023:0] r;
    for (int i = 0; i < 16; i++) r[64*i +: 64] = m_out[i];
    return r;
  endfunction

  task automatic m_seed(input logic [255:0] sd);
    for (int h = 0; h < 2; h++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 4; l++) begin
          int p;
          p = 4*h + 2*w + l/2;
          if (l % 2 == 0) m_st[h][w][l] = consts[2*p] ^ sd[64*seed_of_pair[p] +: 64];
          else            m_st[h][w][l] = consts[2*p+1];
        end
    for (int l = 0; l < 4; l++) m_ct[l] = '0;
  endtask

  // Rotation by 32-bit chunks: rotate left by n chunks
  task automatic m_step(input bit reload);
    logic [63:0] s1c [4], u [4], t0 [4], t1 [4];
    logic [63:0] ns0 [2][4], ns1 [2][4], mx [2][4];
    logic [31:0] ca [8], cb [8];
    for (int h = 0; h < 2; h++) begin
      for (int l = 0; l < 4; l++) begin
        s1c[l] = m_st[h][1][l] + m_ct[l];
        u[l]   = m_st[h][0][l] >> 1;
      end
      for (int i = 0; i < 8; i++) begin
        ca[i] = m_st[h][0][i/2][32*(i%2) +: 32];
        cb[i] = s1c[i/2][32*(i%2) +: 32];
      end
      for (int l = 0; l < 4; l++) begin
        t0[l] = {ca[(2*l+1+5) % 8], ca[(2*l+5) % 8]};
        t1[l] = {cb[(2*l+1+7) % 8], cb[(2*l+7) % 8]};
        ns0[h][l] = t0[l] + u[l];
        ns1[h][l] = t1[l] + (s1c[l] >> 3);
        mx[h][l]  = u[l] ^ t1[l];
      end
    end
    for (int l = 0; l < 4; l++) begin
      m_out[l]      = mx[0][l];
      m_out[4 + l]  = mx[1][l];
      m_out[8 + l]  = ns0[0][l] ^ ns1[1][l];
      m_out[12 + l] = ns1[0][l] ^ ns0[1][l];
    end
    for (int l = 0; l < 4; l++) begin
      if (reload) begin
        m_st[0][0][l] = m_out[12 + l];
        m_st[0][1][l] = m_out[8 + l];
        m_st[1][0][l] = m_out[4 + l];
        m_st[1][1][l] = m_out[l];
      end else begin
        m_st[0][0][l] = ns0[0][l];
        m_st[0][1][l] = ns1[0][l];
        m_st[1][0][l] = ns0[1][l];
        m_st[1][1][l] = ns1[1][l];
      end
      m_ct[l] = m_ct[l] + 64'(7 - 2*l);
    end
  endtask

  task automatic run_seed(input logic [255:0] sd, input int nblk);
    m_seed(sd);
    for (int r = 0; r < 13; r++) m_step(1'b1);
    @(negedge clk);
    seed_i = sd;
    seed_load_i = 1'b1;
    @(negedge clk);
    seed_load_i = 1'b0;
    chk(rdy_o == 1'b0, "R2 rdy low after load", 1024'(rdy_o), 1024'(0));
    for (int c = 1; c < 13; c++) begin
      req_i = 1'($urandom % 2); // R8: ignored during warm-up
      @(negedge clk);
      chk(rdy_o == 1'b0, "R2 rdy low during warm-up", 1024'(rdy_o), 1024'(0));
    end
    req_i = 1'b0;
    @(negedge clk);
    chk(rdy_o == 1'b1, "R2 rdy high after 13 rounds", 1024'(rdy_o), 1024'(1));
    chk(blk_o == m_blk(), "R7 first block after warm-up", blk_o, m_blk());
    for (int b = 0; b < nblk; b++) begin
      int gap;
      gap = $urandom % 3;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chk(blk_o == m_blk(), "R8 block holds without request", blk_o, m_blk());
      end
      req_i = 1'b1;
      @(negedge clk);
      req_i = 1'b0;
      m_step(1'b0);
      chk(blk_o == m_blk(), "R3 R4 R5 R6 R9 block after request", blk_o, m_blk());
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(rdy_o == 1'b0, "R1 rdy low in reset", 1024'(rdy_o), 1024'(0));
    chk(blk_o == '0, "R1 block zero in reset", blk_o, '0);
    rst_n = 1'b1;
    req_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(rdy_o == 1'b0, "R1 rdy low before seeding", 1024'(rdy_o), 1024'(0));
    chk(blk_o == '0, "R1 block zero before seeding", blk_o, '0);
    req_i = 1'b0;
    run_seed('0, 4);
    run_seed({256{1'b1}}, 3);
    run_seed({64'h0, 64'h0, 64'h0, 64'h1}, 3);
    for (int s = 0; s < 3; s++)
      run_seed({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, 6);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule